// File: doc/BRIEF.md
# Interrupt Acknowledge Controller with Spurious Vector Fallback

This block is a single-core slice of a local interrupt controller. Each of its source lines sets a pending bit. Source `i` owns the fixed vector `VEC_BASE + 16*i`, and the upper four bits of any vector are its priority class. While the controller is enabled and some pending source can be delivered, it raises an interrupt line to the core. The core then fetches a vector through a one-cycle acknowledge pulse, and the answer arrives on the following cycle together with a valid strobe.

The core's request can race with software. Between the moment the line is raised and the moment the vector is fetched, software may mask the source or raise the task priority. When that happens, nothing is deliverable at acknowledge time. The block then answers with the vector held in its spurious-vector register and changes no in-service state, so the handler for that vector does not need to write an end-of-interrupt.

A simple write/read port reaches four registers, selected by `wr_addr_i` / `rd_addr_i`:
- 0: the spurious-vector register (vector field, software enable, focus-check bit).
- 1: task priority.
- 2: the per-source masks.
- 3: written with any data as an end-of-interrupt; read as a status word.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x000000FF, so software enable (bit 8) and focus bit (bit 9) are 0. At the same time `irq_o` and `vld_o` are 0, and task priority, masks, pending and in-service bits are all 0.
- R2: Source `i` has vector `VEC_BASE + 16*i`, and its class is vector bits [7:4]. A source is deliverable only when all of the following hold: it is pending, its mask bit (address 2, bit `i`, 1 = masked) is clear, its class is strictly above task-priority bits [7:4], and its class is strictly above the class of the highest set in-service bit (0 if none is set).
- R3: While the controller is enabled, `irq_o` is 1 on the cycle after any source is deliverable. The cycle after an acknowledge it is 0, and on the next cycle it is evaluated again.
- R4: An acknowledge pulse on `ack_i` is answered on the next cycle with `vld_o` high for one cycle. If a source is deliverable, `vec_o` carries the vector of the highest-index deliverable source, and that source's pending bit clears and its in-service bit sets in the same cycle.
- R5: If no source is deliverable at acknowledge time, for example because of a mask or a task-priority raise after `irq_o` rose, `vec_o` carries the spurious vector field. No in-service or pending bit changes.
- R6: Any write to address 3 clears the highest set in-service bit. With none set, it has no effect.
- R7: The controller is enabled only when `glb_en_i` is 1 and software enable is 1. Writes to the software enable bit take effect only while `glb_en_i` is 1. While the controller is disabled, `irq_o` stays 0, pending bits are kept, and an acknowledge returns the spurious vector.
- R8: With `FULL_VEC=0`, bits [7:4] of the vector field are writable and bits [3:0] always read 1 whatever is written. The focus bit (bit 9) is writable, with 0 meaning checking is enabled and 1 meaning it is disabled.
- R9: With `FULL_VEC=1`, all eight vector bits are writable, while bit 9 always reads 0 and ignores writes.
- R10: Reading address 3 returns in-service bits at [NUM_SRC-1:0] and pending bits at [16+NUM_SRC-1:16]. Address 1 reads task priority in [7:0], and address 2 reads the masks in [NUM_SRC-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable; gates the controller and software-enable writes |
| src_i | input | NUM_SRC | Source request lines; a high cycle sets the pending bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Interrupt line to the core |
| ack_i | input | 1 | One-cycle vector acknowledge request |
| vld_o | output | 1 | Vector valid, one cycle after `ack_i` |
| vec_o | output | 8 | Returned vector |

## Verification
Some properties are checked by assertions on every cycle:
- the valid strobe follows each acknowledge after exactly one cycle;
- the line is low right after an acknowledge;
- the line never rises without the enables having been true;
- a spurious answer never disturbs in-service state;
- a real answer always lies above the task priority class;
- the hardwired low vector nibble in the narrow variant.

Other behaviour can only be shown by the bench's scenarios:
- the mask and priority races themselves;
- which vector wins when several sources are pending;
- nesting against in-service classes;
- the order in which end-of-interrupt writes clear bits;
- gated enable writes;
- both register variants' read-back values.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SVR  = 2'd0,
    ADR_TPR  = 2'd1,
    ADR_MASK = 2'd2,
    ADR_EOI  = 2'd3
  } reg_adr_e;

  localparam int unsigned SVR_EN_BIT  = 8;
  localparam int unsigned SVR_FOC_BIT = 9;
  localparam int unsigned STAT_PEND_LSB = 16;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // highest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dlv_filter.sv
module irq_dlv_filter #(
  parameter int unsigned NUM_SRC  = 8,
  parameter logic [7:0]  VEC_BASE = 8'h20
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [3:0]         tpr_cls_i,
  input  logic [3:0]         isr_cls_i,
  output logic [NUM_SRC-1:0] dlv_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam logic [7:0] SrcVec = VEC_BASE + 8'(g * 16);
    localparam logic [3:0] SrcCls = SrcVec[7:4];
    assign dlv_o[g] = pend_i[g] && !mask_i[g]
                   && (SrcCls > tpr_cls_i) && (SrcCls > isr_cls_i);
  end
endmodule

// File: rtl/irq_svr_reg.sv
module irq_svr_reg #(
  parameter bit FULL_VEC = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [9:0] wdata_i,
  input  logic       glb_en_i,
  output logic [7:0] vec_o,
  output logic       sw_en_o,
  output logic       foc_dis_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sw_en_o <= 1'b0;
    else if (wr_i && glb_en_i)  sw_en_o <= wdata_i[8];
  end

  if (FULL_VEC) begin : g_full
    logic [7:0] vec_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   vec_q <= 8'hFF;
      else if (wr_i) vec_q <= wdata_i[7:0];
    end
    assign vec_o     = vec_q;
    assign foc_dis_o = 1'b0;  // reserved
  end else begin : g_narrow
    logic [3:0] hi_q;
    logic       foc_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q  <= 4'hF;
        foc_q <= 1'b0;
      end else if (wr_i) begin
        hi_q  <= wdata_i[7:4];
        foc_q <= wdata_i[9];
      end
    end
    assign vec_o     = {hi_q, 4'hF};
    assign foc_dis_o = foc_q;
  end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter logic [7:0]  VEC_BASE = 8'h20,
  parameter bit          FULL_VEC = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o,
  input  logic               ack_i,
  output logic               vld_o,
  output logic [7:0]         vec_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend_q, isr_q, mask_q, dlv;
  logic [7:0]         tpr_q, svr_vec;
  logic               sw_en, foc_dis, ctl_en;
  logic               dlv_any, isr_any;
  logic [IDX_W-1:0]   dlv_idx, isr_idx;
  logic [7:0]         dlv_vec, isr_vec;
  logic [3:0]         isr_cls;
  logic               svr_wr, tpr_wr, mask_wr, eoi_wr, take;
  logic [NUM_SRC-1:0] take_oh, eoi_oh;

  assign svr_wr  = wr_en_i && (wr_addr_i == ADR_SVR);
  assign tpr_wr  = wr_en_i && (wr_addr_i == ADR_TPR);
  assign mask_wr = wr_en_i && (wr_addr_i == ADR_MASK);
  assign eoi_wr  = wr_en_i && (wr_addr_i == ADR_EOI);

  irq_svr_reg #(.FULL_VEC(FULL_VEC)) u_svr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (svr_wr),
    .wdata_i  (wr_data_i[9:0]),
    .glb_en_i (glb_en_i),
    .vec_o    (svr_vec),
    .sw_en_o  (sw_en),
    .foc_dis_o(foc_dis)
  );

  assign ctl_en = glb_en_i && sw_en;

  irq_prio_enc #(.N(NUM_SRC)) u_isr_enc (
    .req_i(isr_q), .any_o(isr_any), .idx_o(isr_idx)
  );

  assign isr_vec = VEC_BASE + (8'(isr_idx) << 4);
  assign isr_cls = isr_any ? isr_vec[7:4] : 4'h0;

  irq_dlv_filter #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_dlv (
    .pend_i   (pend_q),
    .mask_i   (mask_q),
    .tpr_cls_i(tpr_q[7:4]),
    .isr_cls_i(isr_cls),
    .dlv_o    (dlv)
  );

  irq_prio_enc #(.N(NUM_SRC)) u_dlv_enc (
    .req_i(dlv), .any_o(dlv_any), .idx_o(dlv_idx)
  );

  assign dlv_vec = VEC_BASE + (8'(dlv_idx) << 4);
  assign take    = ack_i && ctl_en && dlv_any;

  always_comb begin
    take_oh = '0;
    eoi_oh  = '0;
    if (take)              take_oh[dlv_idx] = 1'b1;
    if (eoi_wr && isr_any) eoi_oh[isr_idx]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      tpr_q  <= '0;
      irq_o  <= 1'b0;
      vld_o  <= 1'b0;
      vec_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_oh) | src_i;
      isr_q  <= (isr_q & ~eoi_oh) | take_oh;
      if (mask_wr) mask_q <= wr_data_i[NUM_SRC-1:0];
      if (tpr_wr)  tpr_q  <= wr_data_i[7:0];
      irq_o <= !ack_i && ctl_en && dlv_any;
      vld_o <= ack_i;
      if (ack_i) vec_o <= take ? dlv_vec : svr_vec;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADR_SVR: begin
        rd_data_o[7:0]         = svr_vec;
        rd_data_o[SVR_EN_BIT]  = sw_en;
        rd_data_o[SVR_FOC_BIT] = foc_dis;
      end
      ADR_TPR:  rd_data_o[7:0] = tpr_q;
      ADR_MASK: rd_data_o[NUM_SRC-1:0] = mask_q;
      default: begin
        rd_data_o[NUM_SRC-1:0] = isr_q;
        rd_data_o[STAT_PEND_LSB +: NUM_SRC] = pend_q;
      end
    endcase
  end
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
  parameter int unsigned NUM_SRC  = 8,
  parameter bit          FULL_VEC = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               irq_o,
  input logic               vld_o,
  input logic [7:0]         vec_o,
  input logic               glb_en_i,
  input logic               sw_en,
  input logic               dlv_any,
  input logic               eoi_wr,
  input logic [NUM_SRC-1:0] isr_q,
  input logic [7:0]         tpr_q,
  input logic [7:0]         svr_vec
);
  p_vld_follows_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vld_o);

  p_vld_only_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vld_o);

  p_irq_drops_after_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o);

  p_irq_needs_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(glb_en_i && sw_en) |=> !irq_o);

  p_spurious_keeps_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(glb_en_i && sw_en && dlv_any) && !eoi_wr) |=> (isr_q == $past(isr_q)));

  p_real_vec_above_tpr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && glb_en_i && sw_en && dlv_any) |=> (vec_o[7:4] > $past(tpr_q[7:4])));

  p_low_nibble_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    FULL_VEC || (svr_vec[3:0] == 4'hF));
endmodule

bind irq_ack_ctrl irq_ack_chk #(.NUM_SRC(NUM_SRC), .FULL_VEC(FULL_VEC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_i   (ack_i),
  .irq_o   (irq_o),
  .vld_o   (vld_o),
  .vec_o   (vec_o),
  .glb_en_i(glb_en_i),
  .sw_en   (sw_en),
  .dlv_any (dlv_any),
  .eoi_wr  (eoi_wr),
  .isr_q   (isr_q),
  .tpr_q   (tpr_q),
  .svr_vec (svr_vec)
);

// File: tb/irq_ack_ctrl_tb.sv
module irq_ack_ctrl_tb_top;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b1;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic ack = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic irq_a, vld_a, irq_b, vld_b;
  logic [7:0] vec_a, vec_b;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  irq_ack_ctrl #(.NUM_SRC(N), .VEC_BASE(8'h20), .FULL_VEC(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .src_i(src),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_a), .irq_o(irq_a),
    .ack_i(ack), .vld_o(vld_a), .vec_o(vec_a)
  );

  irq_ack_ctrl #(.NUM_SRC(N), .VEC_BASE(8'h20), .FULL_VEC(1'b1)) dut_full_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .src_i(src),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_b), .irq_o(irq_b),
    .ack_i(ack), .vld_o(vld_b), .vec_o(vec_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_a;
  endtask

  task automatic pulse(input logic [N-1:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  // issue ack; returns at the negedge where vld_o should be high
  task automatic do_ack(output logic [7:0] v, output logic irq_now);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    v = vec_a;
    irq_now = irq_a;
    chk("R4 vld_o after ack", {31'd0, vld_a}, 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 svr reset", d, 32'h0000_00FF);
    chk("R1 irq_o reset", {31'd0, irq_a}, 32'd0);
    chk("R1 vld_o reset", {31'd0, vld_a}, 32'd0);
    rd(2'd3, d); chk("R1 status reset", d, 32'd0);
    rd(2'd1, d); chk("R10 tpr reset", d, 32'd0);
  endtask

  task automatic t_svr_variants;
    logic [31:0] d;
    wr(2'd0, 32'h0000_02A5);
    rd(2'd0, d); chk("R8 narrow svr write", d, 32'h0000_02AF);
    chk("R9 full svr write", rd_b, 32'h0000_00A5);
    wr(2'd0, 32'h0000_0130);
    rd(2'd0, d); chk("R8 narrow low nibble kept", d, 32'h0000_013F);
    chk("R9 full svr enable", rd_b, 32'h0000_0130);
  endtask

  task automatic t_enable_gate;
    logic [31:0] d;
    logic [7:0] v;
    logic i;
    glb_en = 1'b0;
    wr(2'd0, 32'h0000_003F);
    rd(2'd0, d); chk("R7 enable write ignored w/o global", d, 32'h0000_013F);
    pulse(8'h08);
    @(negedge clk);
    chk("R7 irq_o low while global off", {31'd0, irq_a}, 32'd0);
    do_ack(v, i);
    chk("R7 ack disabled gives spurious", {24'd0, v}, 32'h3F);
    rd(2'd3, d); chk("R7 pending kept, no isr", d, 32'h0008_0000);
    glb_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 irq_o once enabled", {31'd0, irq_a}, 32'd1);
    wr(2'd0, 32'h0000_003F);  // software disable
    @(negedge clk);
    chk("R7 irq_o low after sw disable", {31'd0, irq_a}, 32'd0);
    rd(2'd3, d); chk("R7 pending retained", d, 32'h0008_0000);
    wr(2'd0, 32'h0000_01A0);
    rd(2'd0, d); chk("R7 re-enable", d, 32'h0000_01AF);
  endtask

  task automatic t_race;
    logic [31:0] d;
    logic [7:0] v;
    logic i;
    @(negedge clk);
    chk("R3 irq_o raised for src3", {31'd0, irq_a}, 32'd1);
    wr(2'd2, 32'h0000_0008);  // mask after line raised
    do_ack(v, i);
    chk("R5 masked race gives spurious", {24'd0, v}, 32'hAF);
    rd(2'd3, d); chk("R5 no isr set after mask race", d, 32'h0008_0000);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0000_0050);  // class 5 == src3 class
    do_ack(v, i);
    chk("R5 tpr race gives spurious", {24'd0, v}, 32'hAF);
    rd(2'd3, d); chk("R5 no isr after tpr race", d, 32'h0008_0000);
    wr(2'd1, 32'h0000_004F);
    rd(2'd1, d); chk("R10 tpr readback", d, 32'h4F);
    do_ack(v, i);
    chk("R4 real vector src3", {24'd0, v}, 32'h50);
    chk("R3 irq_o low after ack", {31'd0, i}, 32'd0);
    rd(2'd3, d); chk("R4 pend->isr", d, 32'h0000_0008);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_nesting;
    logic [31:0] d;
    logic [7:0] v;
    logic i;
    pulse(8'h02);  // class 3 below in-service class 5
    @(negedge clk);
    chk("R2 lower class blocked by isr", {31'd0, irq_a}, 32'd0);
    pulse(8'h60);  // src5, src6
    @(negedge clk);
    chk("R3 irq_o for higher class", {31'd0, irq_a}, 32'd1);
    do_ack(v, i);
    chk("R4 highest of several", {24'd0, v}, 32'h80);
    @(negedge clk);
    chk("R3 irq_o re-evaluated", {31'd0, irq_a}, 32'd0);
    rd(2'd3, d); chk("R10 status nested", d, 32'h0022_0048);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R6 eoi clears top isr", d, 32'h0022_0008);
    @(negedge clk);
    chk("R3 irq_o src5 after eoi", {31'd0, irq_a}, 32'd1);
    do_ack(v, i);
    chk("R4 src5 vector", {24'd0, v}, 32'h70);
    wr(2'd3, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R6 eoi order", d, 32'h0002_0000);
    do_ack(v, i);
    chk("R4 src1 vector", {24'd0, v}, 32'h30);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R6 all clear", d, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R6 eoi with none no effect", d, 32'h0);
    do_ack(v, i);
    chk("R5 nothing pending gives spurious", {24'd0, v}, 32'hAF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_svr_variants();
    t_enable_gate();
    t_race();
    t_nesting();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule